// File: doc/BRIEF.md
# Dual 8-bit Parallel Output Port with Direction Control

This block gives a host two independent 8-bit parallel ports on a small register bus. Each port has an output latch and a data-direction latch. The value driven onto a port's pin bus combines the two latches. A pin whose direction bit is 1 drives the matching output latch bit. A pin whose direction bit is 0 is an input, and the block presents it as a pulled-up 1.

A write to either latch of a port recomputes that port's pin value. The new value appears one clock after the write, together with a one-cycle "updated" pulse for that port. Logic downstream can use this pulse, for example to remap memory when a control pin changes. Reads return the latch contents through a registered read-data bus. Only the low four bits of the register address take part in decoding.

Top module: `pio_dual_port`

## Requirements
- R1: Only address bits [3:0] are decoded. Any value in the upper address bits selects the same register as the low nibble alone.
- R2: Register 0 is the port A output latch and register 1 is the port B output latch. Reads of these registers return the latch contents.
- R3: Register 2 is the port A direction latch and register 3 is the port B direction latch. A 1 bit makes that pin an output. Reads of these registers return the latch contents.
- R4: Each pin bus equals its output latch ORed with the bitwise inverse of its direction latch, so every input-direction pin shows 1.
- R5: A write to either latch of a port updates that port's pin bus in the cycle after the write. Pin buses change at no other time.
- R6: A port's updated pulse is high for exactly one clock, in the cycle after a write to register 0 or 2 (port A) or to register 1 or 3 (port B). It stays low at all other times.
- R7: After reset all four latches are 0x00, both pin buses are 0xFF, both updated pulses are low and read data is 0x00.
- R8: Registers 4 to 15 read as 0x00. Writes to them change no latch, no pin bus and no updated pulse.
- R9: Read data presents the selected register in the cycle after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address; only bits [3:0] are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_pins | output | 8 | Port A pin bus |
| pb_pins | output | 8 | Port B pin bus |
| pa_upd | output | 1 | Port A updated pulse |
| pb_upd | output | 1 | Port B updated pulse |

## Verification
The hardest case to reach is a write that re-presents a port without changing its pin value. Rewriting an output latch while every pin of that port is an input is one example. In that case only the updated pulse shows that the write happened. The random stimulus uses small direction values and repeated writes to the same register, so these cases occur often. Random upper address bits mean every register is also reached through aliased addresses. Separate checks in the idle cycle after each write confirm that the pulse has ended.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PIO_W     = 8;
    localparam int PIO_PORTS = 2;
    localparam int REG_BITS  = 4;

    typedef struct packed {
        logic [PIO_W-1:0] out;
        logic [PIO_W-1:0] dir;
        logic [PIO_W-1:0] pins;
        logic             upd;
    } lane_t;

    typedef struct packed {
        logic [PIO_W-1:0] rdata;
    } rd_t;
endpackage

// File: rtl/pio_reg_decode.sv
module pio_reg_decode #(
    parameter int BUS_ADDR_W = 8,
    parameter int NPORTS     = pio_pkg::PIO_PORTS,
    parameter int RB         = pio_pkg::REG_BITS
) (
    input  logic [BUS_ADDR_W-1:0] addr,
    input  logic                  wr,
    output logic [RB-1:0]         reg_idx,
    output logic [NPORTS-1:0]     wr_out,
    output logic [NPORTS-1:0]     wr_dir
);
    // Register map: outputs at 0..NPORTS-1, directions at NPORTS..2*NPORTS-1
    assign reg_idx = addr[RB-1:0];

    for (genvar p = 0; p < NPORTS; p++) begin : g_sel
        assign wr_out[p] = wr && (reg_idx == RB'(p));
        assign wr_dir[p] = wr && (reg_idx == RB'(NPORTS + p));
    end
endmodule

// File: rtl/pio_port_lane.sv
module pio_port_lane
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_out,
    input  logic             wr_dir,
    input  logic [PIO_W-1:0] wdata,
    output logic [PIO_W-1:0] out_q,
    output logic [PIO_W-1:0] dir_q,
    output logic [PIO_W-1:0] pins,
    output logic             upd
);
    lane_t lane_d, lane_q;

    always_comb begin
        lane_d     = lane_q;
        lane_d.upd = 1'b0;
        if (wr_out) lane_d.out = wdata;
        if (wr_dir) lane_d.dir = wdata;
        if (wr_out || wr_dir) begin
            lane_d.pins = lane_d.out | ~lane_d.dir;
            lane_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q.out  <= '0;
            lane_q.dir  <= '0;
            lane_q.pins <= '1;
            lane_q.upd  <= 1'b0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign out_q = lane_q.out;
    assign dir_q = lane_q.dir;
    assign pins  = lane_q.pins;
    assign upd   = lane_q.upd;
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
    import pio_pkg::*;
#(
    parameter int NPORTS = PIO_PORTS
) (
    input  logic [REG_BITS-1:0]          reg_idx,
    input  logic [NPORTS-1:0][PIO_W-1:0] outs,
    input  logic [NPORTS-1:0][PIO_W-1:0] dirs,
    output logic [PIO_W-1:0]             value
);
    always_comb begin
        value = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (reg_idx == REG_BITS'(p))          value = outs[p];
            if (reg_idx == REG_BITS'(NPORTS + p)) value = dirs[p];
        end
    end
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
    import pio_pkg::*;
#(
    parameter int BUS_ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [PIO_W-1:0]      bus_wdata,
    output logic [PIO_W-1:0]      bus_rdata,
    output logic [PIO_W-1:0]      pa_pins,
    output logic [PIO_W-1:0]      pb_pins,
    output logic                  pa_upd,
    output logic                  pb_upd
);
    localparam int NP = PIO_PORTS;

    logic [REG_BITS-1:0]      reg_idx;
    logic [NP-1:0]            wr_out, wr_dir, upd;
    logic [NP-1:0][PIO_W-1:0] outs, dirs, pins;
    logic [PIO_W-1:0]         rd_value;

    pio_reg_decode #(.BUS_ADDR_W(BUS_ADDR_W), .NPORTS(NP)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .reg_idx (reg_idx),
        .wr_out  (wr_out),
        .wr_dir  (wr_dir)
    );

    for (genvar p = 0; p < NP; p++) begin : g_lane
        pio_port_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_out (wr_out[p]),
            .wr_dir (wr_dir[p]),
            .wdata  (bus_wdata),
            .out_q  (outs[p]),
            .dir_q  (dirs[p]),
            .pins   (pins[p]),
            .upd    (upd[p])
        );
    end

    pio_read_mux #(.NPORTS(NP)) u_rmux (
        .reg_idx (reg_idx),
        .outs    (outs),
        .dirs    (dirs),
        .value   (rd_value)
    );

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) rd_d.rdata = rd_value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
    assign pa_pins   = pins[0];
    assign pb_pins   = pins[1];
    assign pa_upd    = upd[0];
    assign pb_upd    = upd[1];
endmodule

// File: rtl/pio_dual_port_chk.sv
module pio_dual_port_chk #(
    parameter int BUS_ADDR_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BUS_ADDR_W-1:0] bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [7:0]            bus_rdata,
    input logic [7:0]            pa_pins,
    input logic [7:0]            pb_pins,
    input logic                  pa_upd,
    input logic                  pb_upd
);
    logic [3:0] idx;
    logic       hits_a, hits_b;
    assign idx    = bus_addr[3:0];
    assign hits_a = bus_wr && (idx == 4'd0 || idx == 4'd2);
    assign hits_b = bus_wr && (idx == 4'd1 || idx == 4'd3);

    p_reset_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pa_pins == 8'hFF && pb_pins == 8'hFF && !pa_upd && !pb_upd));

    p_upd_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hits_a |=> pa_upd);
    p_upd_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hits_b |=> pb_upd);
    p_no_upd_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hits_a |=> !pa_upd);
    p_no_upd_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hits_b |=> !pb_upd);

    p_pins_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hits_a && !hits_b) |=> ($stable(pa_pins) && $stable(pb_pins)));

    p_unimpl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx >= 4'd4) |=> (bus_rdata == 8'h00));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind pio_dual_port pio_dual_port_chk #(.BUS_ADDR_W(BUS_ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pa_pins   (pa_pins),
    .pb_pins   (pb_pins),
    .pa_upd    (pa_upd),
    .pb_upd    (pb_upd)
);

// File: tb/tb_pio_dual_port.sv
module tb_pio_dual_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pa_pins, pb_pins;
    logic       pa_upd, pb_upd;

    int tests = 0;
    int fails = 0;
    logic [7:0] m_out [2];
    logic [7:0] m_dir [2];
    logic [7:0] m_rd;

    always #10 clk = ~clk;

    pio_dual_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_pins(pa_pins), .pb_pins(pb_pins), .pa_upd(pa_upd), .pb_upd(pb_upd)
    );

    function automatic logic [7:0] pin_of(int p);
        return m_out[p] | ~m_dir[p];
    endfunction

    function automatic logic [7:0] reg_of(logic [3:0] r);
        case (r)
            4'd0: return m_out[0];
            4'd1: return m_out[1];
            4'd2: return m_dir[0];
            4'd3: return m_dir[1];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        logic [3:0] r = a[3:0];
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (r < 4) begin
            if (r < 2) m_out[r[0]] = d;
            else       m_dir[r[0]] = d;
        end
        @(negedge clk);
        bus_wr = 1'b0;
        check("R4/R5 pa_pins", pa_pins, pin_of(0));
        check("R4/R5 pb_pins", pb_pins, pin_of(1));
        check("R6/R8 pa_upd", {7'd0, pa_upd}, {7'd0, (r == 4'd0 || r == 4'd2)});
        check("R6/R8 pb_upd", {7'd0, pb_upd}, {7'd0, (r == 4'd1 || r == 4'd3)});
        @(negedge clk);
        check("R6 pa_upd single cycle", {7'd0, pa_upd}, 8'd0);
        check("R6 pb_upd single cycle", {7'd0, pb_upd}, 8'd0);
        check("R5 pa_pins hold", pa_pins, pin_of(0));
    endtask

    task automatic do_read(logic [7:0] a, string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        m_rd = reg_of(a[3:0]);
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, m_rd);
        @(negedge clk);
        check("R9 rdata hold", bus_rdata, m_rd);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        for (int p = 0; p < 2; p++) begin m_out[p] = '0; m_dir[p] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        check("R7 pa_pins", pa_pins, 8'hFF);
        check("R7 pb_pins", pb_pins, 8'hFF);
        check("R7 upd", {6'd0, pa_upd, pb_upd}, 8'd0);
        check("R7 rdata", bus_rdata, 8'h00);
        do_read(8'h02, "R7/R3 dir A after reset");
        do_read(8'h00, "R7/R2 out A after reset");

        // Directed: R3 direction, R4 composition
        do_write(8'h00, 8'hA5);                 // all inputs -> still FF, upd pulses
        check("R4 inputs pulled up", pa_pins, 8'hFF);
        do_write(8'h02, 8'h0F);
        check("R4 partial outputs", pa_pins, 8'hF5);
        do_write(8'h01, 8'h3C);
        do_write(8'h03, 8'hFF);
        check("R4 full outputs B", pb_pins, 8'h3C);
        do_read(8'h02, "R3 read dir A");
        do_read(8'h03, "R3 read dir B");
        do_read(8'h00, "R2 read out A");
        do_read(8'h01, "R2 read out B");
        // R1: aliased upper bits
        do_write(8'hF0, 8'h11);
        check("R1 alias write A", pa_pins, 8'hF1);
        do_read(8'h72, "R1 alias read dir A");
        // R8: unimplemented registers
        do_write(8'h04, 8'h00);
        do_write(8'hAF, 8'h55);
        do_read(8'h07, "R8 unimplemented read");
        do_read(8'h3E, "R8 unimplemented read high");
        check("R8 pins untouched A", pa_pins, 8'hF1);
        check("R8 pins untouched B", pb_pins, 8'h3C);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, d;
            a = 8'($urandom);
            if ($urandom_range(0, 3) != 0) a[3:0] = 4'($urandom_range(0, 3));
            d = 8'($urandom);
            if ($urandom_range(0, 1) != 0) d = d & 8'h0F;
            if ($urandom_range(0, 2) == 0) do_read(a, "R2/R3/R8/R9 random read");
            else                           do_write(a, d);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule